// File: doc/BRIEF.md
# Slow Clock Quality Monitor

This block judges whether a nominal 32.768 kHz clock is usable. It measures that clock with a fast reference clock of about 48 MHz. The slow clock is brought into the reference domain through a synchroniser. The block then counts reference cycles from one rising edge to the next to get the period, and from a rising edge to the following falling edge to get the high time. For each completed slow cycle it applies up to three checks, each with its own enable:

- a period window;
- a bound on duty-cycle variation;
- a count of consecutive good cycles that must reach a programmed minimum.

Results go into sticky status bits that are cleared by writing 1. A separate stall flag is raised when the slow clock stops toggling. A level interrupt is asserted whenever an enabled status bit is set. A clock is healthy when, after its status has been cleared, it shows ready, period pass, duty pass and valid together, and neither fail nor stall.

Software talks to the block through a plain register port: valid, write, a 4-bit address and 16-bit write data. Read data is combinational from the address. The port never stalls, so it has no back-pressure: a write is taken on the clock edge at which `reg_valid` and `reg_write` are both high. There is no streaming data path.

Top module: `slowclk_qual_mon`

## Requirements
- R1: After reset the registers hold these values, and `irq` is low:

  | Address | Register | Reset value |
  |---|---|---|
  | 0 | control | 0 |
  | 1 | period minimum | 1435 |
  | 2 | period maximum | 1495 |
  | 3 | duty-variation limit | 132 |
  | 4 | valid minimum (8 bits) | 4 |
  | 9 | status | 0 |
  | 10 | interrupt enable | 0 |

- R2: The period is the number of reference cycles between successive detected rising edges. The high time is the number of reference cycles from a rising edge to the next falling edge. The first rising edge after reset or after a clear only arms the measurement. Each later rising edge, while any check is enabled, completes a measurement and sets status bit 0 (ready). Readback addresses: last period at 5, last high time at 6.
- R3: The duty variation, read at address 7, is |high − floor(period/2)|.
- R4: Status bit 1 (period pass) is set when the period check is enabled (control bit 0) and min ≤ period ≤ max. Both bounds are inclusive.
- R5: Status bit 2 (duty pass) is set when the duty check is enabled (control bit 1) and the variation is at most the limit.
- R6: Status bit 4 (fail) is set when an enabled check does not pass. A disabled check neither passes nor fails. With control bits 2:0 all zero, no status is produced.
- R7: The consecutive-valid count, read at address 8, behaves as follows:
  - it goes up by one (saturating) on each completed cycle that does not fail;
  - it drops to 0 on a failing cycle;
  - status bit 3 (valid) is set when control bit 2 is on and the updated count is at least the minimum.
- R8: While any check is enabled, if the reference-cycle count since the last rising edge exceeds twice the period maximum, status bit 5 (stall) is set and the valid count drops to 0.
- R9: Status bits stay set until a 1 is written to them at address 9. Writing 0 to a bit leaves it unchanged. A new event in the same cycle as the write wins over the clear.
- R10: `irq` is high exactly when some status bit and the same bit of the interrupt-enable register (address 10) are both 1.
- R11: Writing control with bit 3 set zeroes the last period, last high time, duty variation, valid count and run counter, and disarms the measurement. Bit 3 reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk_in | input | 1 | Slow clock under test, asynchronous |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach from the ports is a stall that arrives after a run of good cycles: the valid count must first be built up and then be seen to collapse because the clock stopped, not because a cycle failed. The bench drives a train of good cycles with short limits, then holds the slow clock still. It reads status just before and just after the stall threshold of twice the maximum period, and reads the valid count on both sides. The inclusive window edges (min, max, min − 1, max + 1) and a variation exactly equal to the limit are driven as single cycles inside longer trains. This shows that the valid count restarts from zero after each failure.

// File: rtl/sqm_pkg.sv
package sqm_pkg;

  typedef enum logic [3:0] {
    RA_CTRL = 4'd0,
    RA_PMIN = 4'd1,
    RA_PMAX = 4'd2,
    RA_DMAX = 4'd3,
    RA_VMIN = 4'd4,
    RA_PER  = 4'd5,
    RA_HIGH = 4'd6,
    RA_DVAR = 4'd7,
    RA_VCNT = 4'd8,
    RA_STS  = 4'd9,
    RA_IEN  = 4'd10
  } reg_addr_e;

  localparam int CT_PER  = 0;
  localparam int CT_DUTY = 1;
  localparam int CT_VAL  = 2;
  localparam int CT_CLR  = 3;
  localparam int ST_W    = 6;

  // bit order equals the status register layout [5:0]
  typedef struct packed {
    logic stall;
    logic fail;
    logic valid;
    logic dpass;
    logic ppass;
    logic ready;
  } evt_t;

endpackage

// File: rtl/sqm_edge_sync.sv
module sqm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= async_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
  assign fall_o = ~chain_q[STAGES-1] & last_q;
endmodule

// File: rtl/sqm_meter.sv
module sqm_meter
  import sqm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int VC_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             clr_i,
  input  logic             per_en_i,
  input  logic             duty_en_i,
  input  logic             val_en_i,
  input  logic [CNT_W-1:0] lim_min_i,
  input  logic [CNT_W-1:0] lim_max_i,
  input  logic [CNT_W-1:0] lim_duty_i,
  input  logic [VC_W-1:0]  lim_val_i,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] high_o,
  output logic [CNT_W-1:0] dvar_o,
  output logic [VC_W-1:0]  vcnt_o,
  output evt_t             evt_o
);
  localparam int RUN_W = CNT_W + 1;
  localparam logic [RUN_W-1:0] RUN_TOP  = '1;
  localparam logic [RUN_W-1:0] MEAS_TOP = {1'b0, {CNT_W{1'b1}}};
  localparam logic [VC_W-1:0]  VC_TOP   = '1;

  logic [RUN_W-1:0] run_q;
  logic             armed_q;
  logic [CNT_W-1:0] per_q, high_q, dvar_q;
  logic [VC_W-1:0]  vcnt_q;

  logic [CNT_W-1:0] meas_c, half_c, dvar_c;
  logic             per_ok, duty_ok, active, done, bad, stall;
  logic [VC_W-1:0]  vc_next;

  always_comb begin
    meas_c  = (run_q > MEAS_TOP) ? '1 : run_q[CNT_W-1:0];
    half_c  = meas_c >> 1;
    dvar_c  = (high_q >= half_c) ? (high_q - half_c) : (half_c - high_q);
    per_ok  = (meas_c >= lim_min_i) && (meas_c <= lim_max_i);
    duty_ok = (dvar_c <= lim_duty_i);
    active  = per_en_i | duty_en_i | val_en_i;
    done    = rise_i & armed_q & active;
    bad     = (per_en_i & ~per_ok) | (duty_en_i & ~duty_ok);
    vc_next = bad ? '0 : ((vcnt_q == VC_TOP) ? vcnt_q : vcnt_q + 1'b1);
    stall   = active & (run_q > {lim_max_i, 1'b0});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      armed_q <= 1'b0;
      per_q   <= '0;
      high_q  <= '0;
      dvar_q  <= '0;
      vcnt_q  <= '0;
    end else if (clr_i) begin
      run_q   <= '0;
      armed_q <= 1'b0;
      per_q   <= '0;
      high_q  <= '0;
      dvar_q  <= '0;
      vcnt_q  <= '0;
    end else begin
      if (rise_i) run_q <= RUN_W'(1);
      else if (run_q != RUN_TOP) run_q <= run_q + 1'b1;
      if (rise_i) begin
        armed_q <= 1'b1;
        if (armed_q) begin
          per_q  <= meas_c;
          dvar_q <= dvar_c;
        end
      end
      if (fall_i && armed_q) high_q <= meas_c;
      if (stall) vcnt_q <= '0;
      else if (done) vcnt_q <= vc_next;
    end
  end

  assign evt_o.ready = done;
  assign evt_o.ppass = done & per_en_i & per_ok;
  assign evt_o.dpass = done & duty_en_i & duty_ok;
  assign evt_o.fail  = done & bad;
  assign evt_o.valid = done & val_en_i & ~bad & (vc_next >= lim_val_i);
  assign evt_o.stall = stall;

  assign per_o  = per_q;
  assign high_o = high_q;
  assign dvar_o = dvar_q;
  assign vcnt_o = vcnt_q;
endmodule

// File: rtl/sqm_regs.sv
module sqm_regs
  import sqm_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int VC_W     = 8,
  parameter int DEF_MIN  = 1435,
  parameter int DEF_MAX  = 1495,
  parameter int DEF_DUTY = 132,
  parameter int DEF_VAL  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_valid,
  input  logic             reg_write,
  input  logic [3:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] high_i,
  input  logic [CNT_W-1:0] dvar_i,
  input  logic [VC_W-1:0]  vcnt_i,
  input  evt_t             evt_i,
  output logic [2:0]       ctrl_o,
  output logic             clr_o,
  output logic [CNT_W-1:0] lim_min_o,
  output logic [CNT_W-1:0] lim_max_o,
  output logic [CNT_W-1:0] lim_duty_o,
  output logic [VC_W-1:0]  lim_val_o,
  output logic [ST_W-1:0]  sts_o,
  output logic [ST_W-1:0]  ien_o,
  output logic             irq_o
);
  logic [2:0]       ctrl_q;
  logic [CNT_W-1:0] min_q, max_q, duty_q;
  logic [VC_W-1:0]  val_q;
  logic [ST_W-1:0]  sts_q, ien_q, w1c;
  logic             we;
  reg_addr_e        ra;

  assign ra  = reg_addr_e'(reg_addr);
  assign we  = reg_valid & reg_write;
  assign w1c = (we && ra == RA_STS) ? reg_wdata[ST_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      min_q  <= CNT_W'(DEF_MIN);
      max_q  <= CNT_W'(DEF_MAX);
      duty_q <= CNT_W'(DEF_DUTY);
      val_q  <= VC_W'(DEF_VAL);
      ien_q  <= '0;
      sts_q  <= '0;
    end else begin
      if (we) begin
        case (ra)
          RA_CTRL: ctrl_q <= reg_wdata[2:0];
          RA_PMIN: min_q  <= reg_wdata;
          RA_PMAX: max_q  <= reg_wdata;
          RA_DMAX: duty_q <= reg_wdata;
          RA_VMIN: val_q  <= reg_wdata[VC_W-1:0];
          RA_IEN:  ien_q  <= reg_wdata[ST_W-1:0];
          default: ;
        endcase
      end
      sts_q <= (sts_q & ~w1c) | evt_i;
    end
  end

  always_comb begin
    case (ra)
      RA_CTRL: reg_rdata = CNT_W'(ctrl_q);
      RA_PMIN: reg_rdata = min_q;
      RA_PMAX: reg_rdata = max_q;
      RA_DMAX: reg_rdata = duty_q;
      RA_VMIN: reg_rdata = CNT_W'(val_q);
      RA_PER:  reg_rdata = per_i;
      RA_HIGH: reg_rdata = high_i;
      RA_DVAR: reg_rdata = dvar_i;
      RA_VCNT: reg_rdata = CNT_W'(vcnt_i);
      RA_STS:  reg_rdata = CNT_W'(sts_q);
      RA_IEN:  reg_rdata = CNT_W'(ien_q);
      default: reg_rdata = '0;
    endcase
  end

  assign clr_o      = we && (ra == RA_CTRL) && reg_wdata[CT_CLR];
  assign ctrl_o     = ctrl_q;
  assign lim_min_o  = min_q;
  assign lim_max_o  = max_q;
  assign lim_duty_o = duty_q;
  assign lim_val_o  = val_q;
  assign sts_o      = sts_q;
  assign ien_o      = ien_q;
  assign irq_o      = |(sts_q & ien_q);
endmodule

// File: rtl/slowclk_qual_mon.sv
module slowclk_qual_mon
  import sqm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int VC_W        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DEF_MIN     = 1435,
  parameter int DEF_MAX     = 1495,
  parameter int DEF_DUTY    = 132,
  parameter int DEF_VAL     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_clk_in,
  input  logic             reg_valid,
  input  logic             reg_write,
  input  logic [3:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq
);
  logic             rise_w, fall_w, clr_w;
  logic [2:0]       ctrl_w;
  logic [CNT_W-1:0] min_w, max_w, duty_w, per_w, high_w, dvar_w;
  logic [VC_W-1:0]  val_w, vcnt_w;
  logic [ST_W-1:0]  sts_w, ien_w;
  evt_t             evt_w;

  sqm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(slow_clk_in),
    .rise_o(rise_w), .fall_o(fall_w)
  );

  sqm_meter #(.CNT_W(CNT_W), .VC_W(VC_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .rise_i(rise_w), .fall_i(fall_w), .clr_i(clr_w),
    .per_en_i(ctrl_w[CT_PER]), .duty_en_i(ctrl_w[CT_DUTY]), .val_en_i(ctrl_w[CT_VAL]),
    .lim_min_i(min_w), .lim_max_i(max_w), .lim_duty_i(duty_w), .lim_val_i(val_w),
    .per_o(per_w), .high_o(high_w), .dvar_o(dvar_w), .vcnt_o(vcnt_w), .evt_o(evt_w)
  );

  sqm_regs #(
    .CNT_W(CNT_W), .VC_W(VC_W), .DEF_MIN(DEF_MIN), .DEF_MAX(DEF_MAX),
    .DEF_DUTY(DEF_DUTY), .DEF_VAL(DEF_VAL)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .per_i(per_w), .high_i(high_w), .dvar_i(dvar_w), .vcnt_i(vcnt_w), .evt_i(evt_w),
    .ctrl_o(ctrl_w), .clr_o(clr_w), .lim_min_o(min_w), .lim_max_o(max_w),
    .lim_duty_o(duty_w), .lim_val_o(val_w), .sts_o(sts_w), .ien_o(ien_w), .irq_o(irq)
  );
endmodule

// File: rtl/sqm_checker.sv
module sqm_checker #(
  parameter int CNT_W = 16,
  parameter int VC_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_valid,
  input logic             reg_write,
  input logic [3:0]       reg_addr,
  input logic             irq,
  input logic [5:0]       sts,
  input logic [5:0]       ien,
  input logic [VC_W-1:0]  vcnt,
  input logic [CNT_W-1:0] per,
  input logic             done,
  input logic             fail,
  input logic             stall,
  input logic             clr
);
  logic sts_wr;
  assign sts_wr = reg_valid && reg_write && (reg_addr == 4'd9);

  AST_READY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> sts[0]); // R2
  AST_FAIL_ZEROES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail && !clr) |=> (vcnt == '0)); // R7
  AST_GOOD_STEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail && !clr && !stall) |=>
      ((vcnt == $past(vcnt) + 1'b1) || ($past(vcnt) == {VC_W{1'b1}}))); // R7
  AST_STALL_ZEROES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (vcnt == '0)); // R8
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_wr |=> ((sts & $past(sts)) == $past(sts))); // R9
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq); // R10
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((vcnt == '0) && (per == '0))); // R11
endmodule

bind slowclk_qual_mon sqm_checker #(.CNT_W(CNT_W), .VC_W(VC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
  .reg_addr(reg_addr), .irq(irq), .sts(sts_w), .ien(ien_w), .vcnt(vcnt_w),
  .per(per_w), .done(evt_w.ready), .fail(evt_w.fail), .stall(evt_w.stall),
  .clr(clr_w)
);

// File: tb/test_slowclk_qual_mon.sv
module test_slowclk_qual_mon;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow = 1'b0;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  slowclk_qual_mon i_slowclk_qual_mon (
    .clk(clk), .rst_n(rst_n), .slow_clk_in(slow), .reg_valid(reg_valid),
    .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  typedef struct {
    int per; int high; int dvar; int vcnt; int sts;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_bad = 0, outstanding = 0;
  bit   mon_on = 1'b0, finished = 1'b0;
  int   cfg_en = 0, cfg_min = 1435, cfg_max = 1495, cfg_duty = 132, cfg_val = 4, m_vcnt = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = 4'(a);
    #1 v = int'(reg_rdata);
    reg_valid = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 4'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  // expected item from the requirements (R2..R7)
  task automatic push_exp(int p, int h);
    exp_t e;
    int half, dv, ok_p, ok_d, bad;
    half = p / 2;
    dv = (h >= half) ? h - half : half - h;
    ok_p = (p >= cfg_min && p <= cfg_max);
    ok_d = (dv <= cfg_duty);
    bad = ((cfg_en & 1) && !ok_p) || ((cfg_en & 2) && !ok_d);
    m_vcnt = bad ? 0 : ((m_vcnt == 255) ? 255 : m_vcnt + 1);
    e.per = p; e.high = h; e.dvar = dv; e.vcnt = m_vcnt;
    e.sts = 1 | (((cfg_en & 1) && ok_p) ? 2 : 0) | (((cfg_en & 2) && ok_d) ? 4 : 0)
              | (((cfg_en & 4) && !bad && m_vcnt >= cfg_val) ? 8 : 0) | (bad ? 16 : 0);
    exp_q.push_back(e);
    outstanding++;
  endtask

  // driver: one slow cycle starting with a rising edge; measured at the next rise
  task automatic send_pulse(int p, int h, bit push);
    slow = 1'b1;
    repeat (h) @(negedge clk);
    slow = 1'b0;
    repeat (p - h) @(negedge clk);
    if (push) push_exp(p, h);
  endtask

  task automatic close_train();
    slow = 1'b1;
  endtask

  task automatic drain();
    while (outstanding != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor: on interrupt, compare measurements against the queue head
  initial begin
    int v;
    exp_t e;
    forever begin
      @(negedge clk);
      if (mon_on && irq) begin
        if (exp_q.size() == 0) begin
          chk("R6", "unexpected result", 1, 0);
          wr(9, 'h3F);
        end else begin
          e = exp_q.pop_front();
          rd(5, v); chk("R2", "period", v, e.per);
          rd(6, v); chk("R2", "high time", v, e.high);
          rd(7, v); chk("R3", "duty variation", v, e.dvar);
          rd(8, v); chk("R7", "valid count", v, e.vcnt);
          rd(9, v); chk("R4 R5 R6 R7", "status", v, e.sts);
          wr(9, 'h3F);
          outstanding--;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "irq", int'(irq), 0);
    rd(0, v);  chk("R1", "control", v, 0);
    rd(1, v);  chk("R1", "period min", v, 1435);
    rd(2, v);  chk("R1", "period max", v, 1495);
    rd(3, v);  chk("R1", "duty limit", v, 132);
    rd(4, v);  chk("R1", "valid min", v, 4);
    rd(9, v);  chk("R1", "status", v, 0);
    rd(10, v); chk("R1", "irq enable", v, 0);

    // nominal clock at default limits (R2 R3 R5 R7)
    wr(10, 1);
    wr(0, 'hF); cfg_en = 7; m_vcnt = 0;
    rd(0, v); chk("R11", "clear bit reads zero", v, 7);
    mon_on = 1'b1;
    repeat (3) send_pulse(1465, 732, 1);
    send_pulse(1465, 600, 1);   // variation exactly 132
    close_train();
    drain();
    mon_on = 1'b0;
    slow = 1'b0;

    // short limits, window and duty boundaries (R4 R5 R7)
    wr(1, 90); wr(2, 110); wr(3, 8); wr(4, 3);
    cfg_min = 90; cfg_max = 110; cfg_duty = 8; cfg_val = 3;
    wr(0, 'hF); m_vcnt = 0;
    mon_on = 1'b1;
    send_pulse(100, 50, 1);
    send_pulse(90, 45, 1);
    send_pulse(110, 55, 1);
    send_pulse(89, 44, 1);
    send_pulse(111, 55, 1);
    send_pulse(100, 41, 1);
    send_pulse(100, 42, 1);
    send_pulse(100, 58, 1);
    send_pulse(100, 50, 1);
    send_pulse(100, 50, 1);
    close_train();
    drain();
    mon_on = 1'b0;
    slow = 1'b0;

    // period check only: duty ignored (R6)
    wr(0, 'h9); cfg_en = 1; m_vcnt = 0;
    mon_on = 1'b1;
    send_pulse(100, 20, 1);
    send_pulse(120, 60, 1);
    send_pulse(100, 50, 1);
    close_train();
    drain();
    mon_on = 1'b0;
    slow = 1'b0;

    // all checks off: nothing reported (R6)
    wr(9, 'h3F);
    wr(0, 'h8); cfg_en = 0; m_vcnt = 0;
    mon_on = 1'b1;
    send_pulse(100, 50, 0);
    send_pulse(100, 50, 0);
    close_train();
    repeat (10) @(negedge clk);
    mon_on = 1'b0;
    rd(9, v); chk("R6", "status with checks off", v, 0);
    slow = 1'b0;

    // stall after a good run (R8)
    wr(0, 'hF); cfg_en = 7; m_vcnt = 0;
    mon_on = 1'b1;
    repeat (3) send_pulse(100, 50, 1);
    close_train();
    repeat (30) @(negedge clk);
    chk("R7", "results drained", outstanding, 0);
    mon_on = 1'b0;
    rd(8, v); chk("R8", "valid count before stall", v, 3);
    repeat (20) @(negedge clk);
    slow = 1'b0;
    repeat (140) @(negedge clk);
    rd(9, v); chk("R8", "no stall below threshold", v & 'h20, 0);
    repeat (60) @(negedge clk);
    rd(9, v); chk("R8", "stall set", v & 'h20, 'h20);
    rd(8, v); chk("R8", "valid count after stall", v, 0);
    wr(10, 'h20);
    chk("R10", "irq on stall", int'(irq), 1);

    // clear strobe (R11)
    wr(0, 'hF);
    rd(5, v); chk("R11", "period cleared", v, 0);
    rd(6, v); chk("R11", "high cleared", v, 0);
    rd(8, v); chk("R11", "valid cleared", v, 0);

    // sticky status and write-1-to-clear (R9 R10)
    wr(10, 0);
    wr(0, 'hF);
    wr(9, 'h3F);
    send_pulse(100, 50, 0);
    send_pulse(100, 50, 0);
    close_train();
    repeat (8) @(negedge clk);
    rd(9, v); chk("R9", "sticky after two cycles", v, 'h07);
    chk("R10", "irq masked", int'(irq), 0);
    wr(9, 'h01);
    rd(9, v); chk("R9", "only written bit cleared", v, 'h06);
    wr(10, 'h02);
    chk("R10", "irq on enabled bit", int'(irq), 1);
    wr(10, 'h01);
    chk("R10", "irq on cleared bit", int'(irq), 0);
    chk("R2", "queue empty at end", exp_q.size(), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule